// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block builds a Hamming-style parity code over one flash page that arrives as a stream of 8-bit bytes. Every byte adds to three column parity pairs, which split the eight bit positions into complementary halves. The byte's overall parity also adds to a set of row parity pairs, one pair per bit of the byte index. The page can be 512, 1024, 2048 or 4096 bytes, and the number of active row pairs follows that choice: 9, 10, 11 or 12 pairs.

When writing a page, the code produced after the last byte is stored in the spare area. When reading a page back, the stored code is presented with the last byte. The block XORs it with the freshly computed code to form a syndrome and sorts the result into one of four outcomes: no error, a correctable single-bit data error (with the byte index and bit position of the bad bit), a corrupted stored code, or an uncorrectable multiple error. Repairing the buffered data is left to the user.

Top module: `nand_ecc_engine`

## Requirements
- R1: The code word has pair i in bits 2i (unprimed) and 2i+1 (primed). Pairs 0, 1 and 2 are column pairs. Column pair j takes the XOR, over all bytes, of the data bits whose position has bit j set in its unprimed bit, and of the remaining four bits in its primed bit. For example, pair 0 unprimed is bits 7,5,3,1 and pair 0 primed is bits 6,4,2,0.
- R2: Row pair k sits at pair index 3+k. The XOR of all eight bits of a byte goes into its unprimed bit (2(3+k)) when bit k of the byte index is 1. It goes into its primed bit when bit k is 0. The first byte of a page has index 0.
- R3: pageSel 0, 1, 2, 3 selects 512, 1024, 2048, 4096 bytes, giving 9+pageSel active row pairs. Inactive row pairs read as zero in codeOut, and the matching storedCode bits are ignored.
- R4: done pulses for exactly one cycle, one cycle after the byte flagged inLast. codeOut and the outcome flags stay valid from then until the next clear.
- R5: A byte with inFirst restarts the accumulation and clears codeOut and all outcome outputs in the next cycle, unless that same byte is also the last byte.
- R6: softClr clears the accumulation, codeOut, done and all outcome outputs in the next cycle, and aborts any page in progress.
- R7: In check mode (checkEn high at the last byte), a masked syndrome of zero sets errNone.
- R8: In check mode, if every active pair has exactly one syndrome bit set, errData is raised. errByte then holds the unprimed row syndrome bits (row pair k gives bit k), and errBit holds the unprimed column syndrome bits (column pair j gives bit j).
- R9: In check mode, a syndrome with exactly one bit set raises errCode.
- R10: In check mode, any other non-zero syndrome raises errMulti. At most one outcome flag is ever high.
- R11: With checkEn low at the last byte, all four outcome flags and errByte/errBit stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| softClr | input | 1 | Synchronous clear of all state and results |
| pageSel | input | 2 | Page size select, taken with the first byte |
| checkEn | input | 1 | Compare against storedCode at the last byte |
| inValid | input | 1 | Byte strobe |
| inFirst | input | 1 | Byte is the first of a page |
| inLast | input | 1 | Byte is the last of a page |
| inData | input | 8 | Page byte |
| storedCode | input | 30 | Code read from the flash, sampled with the last byte |
| done | output | 1 | One-cycle result strobe |
| codeOut | output | 30 | Computed code of the last page |
| errNone | output | 1 | Check found no error |
| errData | output | 1 | Correctable single data-bit error |
| errCode | output | 1 | The stored code itself is corrupted |
| errMulti | output | 1 | Uncorrectable error |
| errByte | output | 12 | Byte index of the correctable error |
| errBit | output | 3 | Bit position of the correctable error |

## Verification
The assertions assume that every page starts with an inFirst byte. They also assume that inFirst, inLast, pageSel, checkEn and storedCode only matter on cycles where inValid is high, and that a page never carries more bytes than its selected size. Without these, the byte index would run past the active row pairs. The stimulus always streams complete pages of exactly 512·2^pageSel bytes that open with inFirst. It only aborts a partial page through softClr. A behavioural reference model checks every cycle, and directed corruptions of data bits and stored-code bits cover each of the four outcomes for several page sizes.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wipe;   // software clear
    logic take;   // accept a byte
    logic open;   // byte starts a page
    logic close;  // byte ends a page
  } eccStrobe_t;
endpackage

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
#(
  parameter int MAX_LOG = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               softClr,
  input  logic               inValid,
  input  logic               inFirst,
  input  logic               inLast,
  input  logic [1:0]         pageSel,
  output eccStrobe_t         strb,
  output logic [MAX_LOG-1:0] byteIdx,
  output logic [1:0]         effSel
);
  logic [MAX_LOG-1:0] idxReg;
  logic [1:0]         selReg;

  always_comb begin
    strb.wipe  = softClr;
    strb.take  = inValid & ~softClr;
    strb.open  = strb.take & inFirst;
    strb.close = strb.take & inLast;
    byteIdx    = strb.open ? '0 : idxReg;
    effSel     = strb.open ? pageSel : selReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg <= '0;
      selReg <= '0;
    end else if (strb.wipe) begin
      idxReg <= '0;
    end else if (strb.take) begin
      idxReg <= byteIdx + 1'b1;
      if (strb.open) selReg <= pageSel;
    end
  end

  // R2: the byte index advances by one for each accepted byte
  assert_index_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> idxReg == $past(byteIdx) + 1'b1);
  // R6: a software clear sends the index back to zero
  assert_index_wipe_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wipe |=> idxReg == '0);
endmodule

// File: rtl/nand_ecc_datapath.sv
module nand_ecc_datapath
  import nand_ecc_pkg::*;
#(
  parameter int MAX_LOG = 12,
  parameter int MIN_LOG = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  eccStrobe_t              strb,
  input  logic [7:0]              inData,
  input  logic [MAX_LOG-1:0]      byteIdx,
  input  logic [1:0]              effSel,
  input  logic                    checkEn,
  input  logic [6+2*MAX_LOG-1:0]  storedCode,
  output logic                    done,
  output logic [6+2*MAX_LOG-1:0]  codeOut,
  output logic                    errNone,
  output logic                    errData,
  output logic                    errCode,
  output logic                    errMulti,
  output logic [MAX_LOG-1:0]      errByte,
  output logic [2:0]              errBit
);
  localparam int COLS   = 3;
  localparam int PAIRS  = COLS + MAX_LOG;
  localparam int CODE_W = 2 * PAIRS;

  logic [CODE_W-1:0]  acc, contrib, nextAcc, codeMask, syndrome;
  logic [MAX_LOG-1:0] rowMask, locByte;
  logic [2:0]         locBit;
  logic               bytePar, pairsOk, synZero, synSingle;

  always_comb begin
    bytePar = ^inData;
    contrib = '0;
    for (int j = 0; j < COLS; j++) begin
      for (int p = 0; p < 8; p++) begin
        if (((p >> j) & 1) == 1) contrib[2*j]   = contrib[2*j]   ^ inData[p];
        else                     contrib[2*j+1] = contrib[2*j+1] ^ inData[p];
      end
    end
    for (int k = 0; k < MAX_LOG; k++) begin
      rowMask[k] = (k < MIN_LOG + int'(effSel));
      contrib[2*(COLS+k)]   = rowMask[k] & bytePar &  byteIdx[k];
      contrib[2*(COLS+k)+1] = rowMask[k] & bytePar & ~byteIdx[k];
      codeMask[2*(COLS+k)]   = rowMask[k];
      codeMask[2*(COLS+k)+1] = rowMask[k];
      locByte[k] = syndrome[2*(COLS+k)];
    end
    codeMask[2*COLS-1:0] = '1;
    nextAcc  = (strb.open ? '0 : acc) ^ contrib;
    syndrome = (nextAcc ^ storedCode) & codeMask;
    pairsOk  = 1'b1;
    for (int i = 0; i < PAIRS; i++) begin
      if (codeMask[2*i] && !(syndrome[2*i] ^ syndrome[2*i+1])) pairsOk = 1'b0;
    end
    for (int j = 0; j < COLS; j++) locBit[j] = syndrome[2*j];
    synZero   = (syndrome == '0);
    synSingle = ($countones(syndrome) == 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0; codeOut <= '0; done <= 1'b0;
      errNone <= 1'b0; errData <= 1'b0; errCode <= 1'b0; errMulti <= 1'b0;
      errByte <= '0; errBit <= '0;
    end else if (strb.wipe) begin
      acc <= '0; codeOut <= '0; done <= 1'b0;
      errNone <= 1'b0; errData <= 1'b0; errCode <= 1'b0; errMulti <= 1'b0;
      errByte <= '0; errBit <= '0;
    end else begin
      done <= 1'b0;
      if (strb.open) begin
        codeOut <= '0;
        errNone <= 1'b0; errData <= 1'b0; errCode <= 1'b0; errMulti <= 1'b0;
        errByte <= '0; errBit <= '0;
      end
      if (strb.take) acc <= nextAcc;
      if (strb.close) begin
        codeOut <= nextAcc;
        done    <= 1'b1;
        errNone <= checkEn & synZero;
        errData <= checkEn & !synZero & pairsOk;
        errCode <= checkEn & !pairsOk & synSingle;
        errMulti <= checkEn & !synZero & !pairsOk & !synSingle;
        errByte <= (checkEn & !synZero & pairsOk) ? locByte : '0;
        errBit  <= (checkEn & !synZero & pairsOk) ? locBit  : '0;
      end
    end
  end

  // R4: a last byte is followed by the result strobe
  assert_done_follows_last_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.close |=> done);
  // R4: done never repeats on back-to-back cycles without a new last byte
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    done && !strb.close |=> !done);
  // R10: outcome flags are mutually exclusive
  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errNone, errData, errCode, errMulti}));
  // R6: software clear empties the results
  assert_wipe_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wipe |=> (!done && codeOut == '0 && !errData && !errMulti));
  // R11: write mode leaves every flag low
  assert_write_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.close && !checkEn |=> !(errNone | errData | errCode | errMulti));
  // R3: the topmost row pair is only used by the largest page
  assert_top_row_masked_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.close && effSel != 2'd3 |=> codeOut[CODE_W-1 -: 2] == 2'b00);
endmodule

// File: rtl/nand_ecc_engine.sv
module nand_ecc_engine
  import nand_ecc_pkg::*;
#(
  parameter int MAX_LOG = 12,
  parameter int MIN_LOG = 9
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   softClr,
  input  logic [1:0]             pageSel,
  input  logic                   checkEn,
  input  logic                   inValid,
  input  logic                   inFirst,
  input  logic                   inLast,
  input  logic [7:0]             inData,
  input  logic [6+2*MAX_LOG-1:0] storedCode,
  output logic                   done,
  output logic [6+2*MAX_LOG-1:0] codeOut,
  output logic                   errNone,
  output logic                   errData,
  output logic                   errCode,
  output logic                   errMulti,
  output logic [MAX_LOG-1:0]     errByte,
  output logic [2:0]             errBit
);
  eccStrobe_t         strb;
  logic [MAX_LOG-1:0] byteIdx;
  logic [1:0]         effSel;

  nand_ecc_ctrl #(.MAX_LOG(MAX_LOG)) uCtrl (
    .clk(clk), .rstN(rstN), .softClr(softClr), .inValid(inValid),
    .inFirst(inFirst), .inLast(inLast), .pageSel(pageSel),
    .strb(strb), .byteIdx(byteIdx), .effSel(effSel)
  );

  nand_ecc_datapath #(.MAX_LOG(MAX_LOG), .MIN_LOG(MIN_LOG)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData), .byteIdx(byteIdx),
    .effSel(effSel), .checkEn(checkEn), .storedCode(storedCode),
    .done(done), .codeOut(codeOut), .errNone(errNone), .errData(errData),
    .errCode(errCode), .errMulti(errMulti), .errByte(errByte), .errBit(errBit)
  );
endmodule

// File: tb/sim_nand_ecc_engine.sv
`timescale 1ns/1ps
module sim_nand_ecc_engine;
  logic        clk = 0, rstN = 0, softClr = 0, checkEn = 0;
  logic        inValid = 0, inFirst = 0, inLast = 0;
  logic [1:0]  pageSel = 0;
  logic [7:0]  inData = 0;
  logic [29:0] storedCode = 0;
  logic        done, errNone, errData, errCode, errMulti;
  logic [29:0] codeOut;
  logic [11:0] errByte;
  logic [2:0]  errBit;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] pageData [0:4095];

  always #4 clk = ~clk;

  nand_ecc_engine u0 (.*);

  // behavioural contribution of one byte
  function automatic logic [29:0] byteCode(logic [7:0] d, int idx, int sel);
    logic [29:0] c = '0;
    for (int pos = 0; pos < 8; pos++)
      if (d[pos])
        for (int j = 0; j < 3; j++)
          if ((pos >> j) % 2 == 1) c[2*j] = ~c[2*j]; else c[2*j+1] = ~c[2*j+1];
    if (^d)
      for (int k = 0; k < 9 + sel; k++)
        if ((idx >> k) % 2 == 1) c[6+2*k] = ~c[6+2*k]; else c[7+2*k] = ~c[7+2*k];
    return c;
  endfunction

  function automatic logic [29:0] pageCode(int sel);
    logic [29:0] c = '0;
    for (int i = 0; i < (512 << sel); i++) c ^= byteCode(pageData[i], i, sel);
    return c;
  endfunction

  // reference model, updated at each rising edge
  logic [29:0] mAcc, eCode;
  logic        eDone, eNone, eData, eCodeErr, eMulti;
  logic [11:0] eByte;
  logic [2:0]  eBit;
  int          mIdx, mSel;

  task automatic modelClear();
    mAcc = 0; eCode = 0; eDone = 0; eNone = 0; eData = 0; eCodeErr = 0; eMulti = 0;
    eByte = 0; eBit = 0; mIdx = 0;
  endtask

  always @(posedge clk) begin
    if (!rstN || softClr) begin
      modelClear();
      if (!rstN) mSel = 0;
    end else begin
      eDone = 0;
      if (inValid) begin
        if (inFirst) begin
          modelClear(); mSel = int'(pageSel);
        end
        mAcc ^= byteCode(inData, mIdx, mSel);
        mIdx++;
        if (inLast) begin
          logic [29:0] syn;
          bit allPairs;
          eCode = mAcc; eDone = 1;
          syn = mAcc ^ storedCode;
          for (int k = 9 + mSel; k < 12; k++) begin syn[6+2*k] = 0; syn[7+2*k] = 0; end
          allPairs = 1;
          for (int i = 0; i < 12 + mSel; i++) if (syn[2*i] == syn[2*i+1]) allPairs = 0;
          if (checkEn) begin
            if (syn == 0) eNone = 1;
            else if (allPairs) begin
              eData = 1;
              for (int k = 0; k < 12; k++) eByte[k] = syn[6+2*k];
              eBit = {syn[4], syn[2], syn[0]};
            end else if ($countones(syn) == 1) eCodeErr = 1;
            else eMulti = 1;
          end
        end
      end
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison
  always @(negedge clk) if (rstN && !finished) begin
    check(codeOut == eCode, "R1 R2 R3 codeOut", {2'b0, codeOut}, {2'b0, eCode});
    check(done == eDone, "R4 done", done, eDone);
    check({errNone, errData, errCode, errMulti} == {eNone, eData, eCodeErr, eMulti},
          "R7 R8 R9 R10 flags", {errNone, errData, errCode, errMulti},
          {eNone, eData, eCodeErr, eMulti});
    check({errByte, errBit} == {eByte, eBit}, "R8 location", {errByte, errBit}, {eByte, eBit});
  end

  task automatic sendPage(int sel, bit chk, logic [29:0] stored, int nBytes, bit withLast);
    for (int i = 0; i < nBytes; i++) begin
      @(negedge clk);
      inValid = 1; inData = pageData[i]; pageSel = 2'(sel); checkEn = chk;
      storedCode = stored; inFirst = (i == 0); inLast = withLast && (i == nBytes - 1);
    end
    @(negedge clk);
    inValid = 0; inFirst = 0; inLast = 0;
  endtask

  logic [29:0] good;

  initial begin
    for (int i = 0; i < 4096; i++) pageData[i] = 8'((i * 37 + 11) ^ (i >> 3) * 5);
    repeat (3) @(negedge clk);
    check(!done && codeOut == 0 && !errNone, "R6 reset state", codeOut, 0);
    rstN = 1;

    // write mode, 512 bytes
    good = pageCode(0);
    sendPage(0, 0, 30'h0, 512, 1);
    check(done && codeOut == good, "R1 R2 write code", codeOut, good);
    check(!(errNone | errData | errCode | errMulti), "R11 write quiet", errNone, 0);
    check(codeOut[29:24] == 0, "R3 unused rows zero", codeOut[29:24], 0);
    @(negedge clk);
    check(!done && codeOut == good, "R4 single pulse, held", done, 0);

    // clean read, junk in unused pairs is ignored
    sendPage(0, 1, good | 30'h3F00_0000, 512, 1);
    check(errNone, "R7 R3 clean read", errNone, 1);

    // single data bit error, 1024 bytes
    good = pageCode(1);
    pageData[777] ^= 8'h20;
    sendPage(1, 1, good, 1024, 1);
    check(errData && errByte == 777 && errBit == 5, "R8 data error location",
          {errData, errByte, errBit}, {1'b1, 12'd777, 3'd5});
    pageData[777] ^= 8'h20;

    // start of next page clears results
    sendPage(1, 1, good, 1, 0);
    check(!errData && errByte == 0 && codeOut == 0, "R5 new page clears", errData, 0);
    softClr = 1; @(negedge clk); softClr = 0;

    // stored code corrupted, 2048 bytes
    good = pageCode(2);
    sendPage(2, 1, good ^ 30'h200, 2048, 1);
    check(errCode, "R9 code error", errCode, 1);

    // two data errors, 4096 bytes
    good = pageCode(3);
    pageData[100] ^= 8'h08; pageData[3000] ^= 8'h08;
    sendPage(3, 1, good, 4096, 1);
    check(errMulti, "R10 multiple error", errMulti, 1);
    pageData[100] ^= 8'h08; pageData[3000] ^= 8'h08;

    // clean 4096-byte check, then software clear
    sendPage(3, 1, good, 4096, 1);
    check(errNone && codeOut == good, "R7 R3 large page", errNone, 1);
    softClr = 1; @(negedge clk); softClr = 0;
    check(codeOut == 0 && !errNone && !done, "R6 soft clear", codeOut, 0);

    // abort mid page with soft clear, then full page
    sendPage(0, 0, 30'h0, 200, 0);
    softClr = 1; @(negedge clk); softClr = 0;
    good = pageCode(0);
    sendPage(0, 1, good, 512, 1);
    check(errNone && codeOut == good, "R6 abort then restart", codeOut, good);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule